// File: doc/BRIEF.md
# SPI Master Interrupt Status and Mask Bank

This block gathers the interrupt-worthy conditions of an SPI master into one status register and raises a single interrupt request line. The conditions are a mode-fault event, the TX FIFO dropping below a programmable watermark, the TX FIFO being full, and the RX FIFO holding data. Software acknowledges a status bit by writing a one to it. This lets a handler read the status word and write the same word back to clear exactly what it saw.

The interrupt mask cannot be written directly. One write-only address sets mask bits wherever the written word has ones. A second write-only address clears mask bits wherever the written word has ones. A read-only address shows the current mask. The watermark compared against the TX FIFO fill level is a read/write register. The FIFOs and the shift engine sit outside this block. They supply a fill level, flags and a one-cycle fault pulse. Registers are reached through a plain single-cycle write strobe with address and data, and a combinational read-data bus selected by the same address.

Top module: `spi_irq_bank`

## Requirements
- R1: After reset the status reads 0, the mask reads 0, the watermark reads 1 and the interrupt line is low.
- R2: Every register that carries interrupt bits uses the same layout. Bit 1 is mode fault, bit 2 is TX level below watermark, bit 3 is TX full and bit 4 is RX not empty. Bits 0, 5 and 6 exist in the mask but always read 0 in the status. Bits above 6 read 0, and unmapped addresses read 0.
- R3: A write to byte offset 0x04 clears each status bit whose written bit is one and leaves the others alone. A read of 0x04 returns the status.
- R4: A write to 0x08 sets the mask bits that are one in the data, and a write to 0x0C clears them. Zero data bits leave the mask unchanged, and data bits above 6 are ignored. 0x10 reads back the mask, and 0x08 and 0x0C read 0.
- R5: Offset 0x28 is the read/write TX watermark, as wide as the level input. The below-watermark condition is true when the TX level is strictly less than the watermark.
- R6: The mode-fault bit is set one cycle after a fault pulse and stays set until cleared. A fault pulse in the same cycle as a clear of that bit leaves the bit set.
- R7: The three level bits (bits 2, 3, 4) show their condition as sampled one clock earlier, with no write needed to drop them. A clear forces such a bit to 0 for one cycle, after which it re-asserts if the condition still holds.
- R8: The interrupt line is the OR of status AND mask, registered. It changes one cycle after the status does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W (6) | Byte offset for write and read |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Read data for regAddr, combinational |
| txLevel | input | LVL_W (8) | TX FIFO fill level |
| txFull | input | 1 | TX FIFO full flag |
| rxEmpty | input | 1 | RX FIFO empty flag |
| modeFault | input | 1 | One-cycle mode-fault event |
| irqOut | output | 1 | Interrupt request |

## Verification
The mask is driven through all 128 patterns. Each pattern is set with junk in the upper data bits, then hit with an all-zero set and a partial clear, so set, hold and clear are told apart bit by bit. The watermark comparison is swept over fill levels around several watermarks, including 0 and the maximum, which separates strict from inclusive compare. All 16 combinations of the four sources are crossed with eight masks, and the status word and the interrupt line are checked against arithmetic predictions. Directed sequences then pin down clear-then-reassert timing, the fault-versus-clear collision and the one-cycle interrupt latency.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int IRQ_BITS    = 7;
  localparam int BIT_MODF    = 1;
  localparam int BIT_TXLOW   = 2;
  localparam int BIT_TXFULL  = 3;
  localparam int BIT_RXAVAIL = 4;

  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_SET    = 8'h08;
  localparam logic [7:0] OFS_CLR    = 8'h0C;
  localparam logic [7:0] OFS_MASK   = 8'h10;
  localparam logic [7:0] OFS_WMARK  = 8'h28;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK,
    RD_WMARK
  } rdSel_e;

  typedef struct packed {
    logic   ackStatus;
    logic   maskSet;
    logic   maskClr;
    logic   wmarkWr;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  logic [7:0] addrByte;

  assign addrByte = 8'(regAddr);

  always_comb begin
    strobe.ackStatus = regWrEn && (addrByte == OFS_STATUS);
    strobe.maskSet   = regWrEn && (addrByte == OFS_SET);
    strobe.maskClr   = regWrEn && (addrByte == OFS_CLR);
    strobe.wmarkWr   = regWrEn && (addrByte == OFS_WMARK);
    case (addrByte)
      OFS_STATUS: strobe.rdSel = RD_STATUS;
      OFS_MASK:   strobe.rdSel = RD_MASK;
      OFS_WMARK:  strobe.rdSel = RD_WMARK;
      default:    strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LVL_W    = 8,
  parameter int WM_RESET = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic              modeFault,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [IRQ_BITS-1:0] statusQ;
  logic [IRQ_BITS-1:0] maskQ;
  logic [LVL_W-1:0]    wmarkQ;
  logic [IRQ_BITS-1:0] wrBits;
  logic [IRQ_BITS-1:0] ackBits;
  logic [IRQ_BITS-1:0] condVec;
  logic [IRQ_BITS-1:0] setBits;
  logic [IRQ_BITS-1:0] clrBits;
  logic                irqQ;

  assign wrBits  = wrData[IRQ_BITS-1:0];
  assign ackBits = strobe.ackStatus ? wrBits : '0;
  assign setBits = strobe.maskSet ? wrBits : '0;
  assign clrBits = strobe.maskClr ? wrBits : '0;

  always_comb begin
    condVec              = '0;
    condVec[BIT_TXLOW]   = txLevel < wmarkQ;
    condVec[BIT_TXFULL]  = txFull;
    condVec[BIT_RXAVAIL] = !rxEmpty;
  end

  for (genvar i = 0; i < IRQ_BITS; i++) begin : gStatus
    if (i == BIT_MODF) begin : gSticky
      always_ff @(posedge clk) begin
        if (!rstN) statusQ[i] <= 1'b0;
        else       statusQ[i] <= (statusQ[i] && !ackBits[i]) || modeFault;
      end
    end else if (i == BIT_TXLOW || i == BIT_TXFULL || i == BIT_RXAVAIL) begin : gLevel
      always_ff @(posedge clk) begin
        if (!rstN) statusQ[i] <= 1'b0;
        else       statusQ[i] <= condVec[i] && !ackBits[i];
      end
    end else begin : gSpare
      assign statusQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '0;
    else if (strobe.maskSet || strobe.maskClr) maskQ <= (maskQ | setBits) & ~clrBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               wmarkQ <= LVL_W'(WM_RESET);
    else if (strobe.wmarkWr) wmarkQ <= wrData[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusQ & maskQ);
  end
  assign irqOut = irqQ;

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_STATUS: rdData[IRQ_BITS-1:0] = statusQ;
      RD_MASK:   rdData[IRQ_BITS-1:0] = maskQ;
      RD_WMARK:  rdData[LVL_W-1:0]    = wmarkQ;
      default:   rdData = '0;
    endcase
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSet && !strobe.maskClr |=> ((maskQ & $past(wrBits)) == $past(wrBits))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskClr |=> ((maskQ & $past(wrBits)) == '0)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskSet && !strobe.maskClr |=> $stable(maskQ)); // R4
  AST_MODF_CATCH: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> statusQ[BIT_MODF]); // R6
  AST_MODF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[BIT_MODF] && !(strobe.ackStatus && wrBits[BIT_MODF]) |=> statusQ[BIT_MODF]); // R6
  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |=> !statusQ[BIT_RXAVAIL]); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) && ($past(maskQ) == '0) |-> !irqOut); // R8
endmodule

// File: rtl/spi_irq_bank.sv
module spi_irq_bank
  import spi_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int LVL_W    = 8,
  parameter int WM_RESET = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic              modeFault,
  output logic              irqOut
);
  regStrobe_t strobe;

  spi_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  spi_irq_datapath #(
    .DATA_W   (DATA_W),
    .LVL_W    (LVL_W),
    .WM_RESET (WM_RESET)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .txLevel   (txLevel),
    .txFull    (txFull),
    .rxEmpty   (rxEmpty),
    .modeFault (modeFault),
    .rdData    (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/spi_irq_bank_tb_top.sv
module spi_irq_bank_tb_top;
  localparam logic [5:0] A_STAT = 6'h04;
  localparam logic [5:0] A_SET  = 6'h08;
  localparam logic [5:0] A_CLR  = 6'h0C;
  localparam logic [5:0] A_MASK = 6'h10;
  localparam logic [5:0] A_WM   = 6'h28;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [5:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [7:0]  txLevel;
  logic        txFull;
  logic        rxEmpty;
  logic        modeFault;
  logic        irqOut;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  spi_irq_bank dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txLevel(txLevel),
    .txFull(txFull), .rxEmpty(rxEmpty), .modeFault(modeFault), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [6:0] expSt;
    logic [7:0] wmList [5];
    logic [6:0] mList [8];
    wmList = '{8'd0, 8'd1, 8'd3, 8'd8, 8'd255};
    mList  = '{7'h00, 7'h02, 7'h04, 7'h08, 7'h10, 7'h1E, 7'h7F, 7'h61};
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    txLevel = 8'd5; txFull = 1'b0; rxEmpty = 1'b1; modeFault = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0);
    rd(A_WM, d);   chk("R1 watermark", d, 32'h1);
    chk("R1 irq", {31'h0, irqOut}, 32'h0);

    // R4 mask sweep over all patterns
    for (int v = 0; v < 128; v++) begin
      wr(A_CLR, 32'h7F);
      wr(A_SET, {25'h1FFFFFF, 7'(v)});
      rd(A_MASK, d); chk("R4 set", d, 32'(v));
      wr(A_SET, 32'h0);
      rd(A_MASK, d); chk("R4 zero-set hold", d, 32'(v));
      wr(A_CLR, 32'hFFFFFF2A);
      rd(A_MASK, d); chk("R4 partial clear", d, 32'(v & 8'hD5));
    end
    rd(A_SET, d); chk("R4 set reads 0", d, 32'h0);
    rd(A_CLR, d); chk("R4 clear reads 0", d, 32'h0);
    rd(6'h00, d); chk("R2 unmapped reads 0", d, 32'h0);

    // R5 watermark compare sweep
    for (int w = 0; w < 5; w++) begin
      wr(A_WM, {24'hABCDEF, wmList[w]});
      rd(A_WM, d); chk("R5 watermark readback", d, {24'h0, wmList[w]});
      for (int l = 0; l <= 21; l++) begin
        txLevel = (l == 21) ? 8'd255 : 8'(l);
        @(negedge clk);
        rd(A_STAT, d);
        chk("R5 below-watermark bit", {31'h0, d[2]}, {31'h0, txLevel < wmList[w]});
      end
    end
    wr(A_WM, 32'h1);

    // R2/R8 all source combinations crossed with masks
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 8; m++) begin
        txLevel = c[1] ? 8'd0 : 8'd200;
        txFull  = c[2];
        rxEmpty = !c[3];
        wr(A_CLR, 32'h7F);
        wr(A_SET, {25'h0, mList[m]});
        wr(A_STAT, 32'h7F);
        if (c[0]) begin
          modeFault = 1'b1; @(negedge clk); modeFault = 1'b0;
        end
        repeat (2) @(negedge clk);
        expSt = {2'b00, 4'(c), 1'b0};
        rd(A_STAT, d); chk("R2 status layout", d, {25'h0, expSt});
        chk("R8 irq level", {31'h0, irqOut}, {31'h0, |(expSt & mList[m])});
      end
    end
    txLevel = 8'd200; txFull = 1'b0; rxEmpty = 1'b1;
    wr(A_STAT, 32'h7F);
    wr(A_CLR, 32'h7F);

    // R8 latency
    wr(A_SET, 32'h08);
    repeat (2) @(negedge clk);
    chk("R8 irq idle", {31'h0, irqOut}, 32'h0);
    txFull = 1'b1;
    @(negedge clk);
    rd(A_STAT, d); chk("R8 status first", {31'h0, d[3]}, 32'h1);
    chk("R8 irq lags status", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    chk("R8 irq rises", {31'h0, irqOut}, 32'h1);
    txFull = 1'b0;
    @(negedge clk);
    chk("R8 irq held one cycle", {31'h0, irqOut}, 32'h1);
    @(negedge clk);
    chk("R8 irq falls", {31'h0, irqOut}, 32'h0);

    // R7 clear then re-assert
    txFull = 1'b1;
    repeat (2) @(negedge clk);
    wr(A_STAT, 32'h08);
    rd(A_STAT, d); chk("R7 cleared for one cycle", {31'h0, d[3]}, 32'h0);
    @(negedge clk);
    rd(A_STAT, d); chk("R7 re-asserted", {31'h0, d[3]}, 32'h1);
    txFull = 1'b0;

    // R7 rx bit drops without a write
    rxEmpty = 1'b0;
    @(negedge clk);
    rd(A_STAT, d); chk("R7 rx not empty", {31'h0, d[4]}, 32'h1);
    rxEmpty = 1'b1;
    @(negedge clk);
    rd(A_STAT, d); chk("R7 rx drops", {31'h0, d[4]}, 32'h0);

    // R3 selective clear, R6 sticky
    rxEmpty = 1'b0;
    modeFault = 1'b1; @(negedge clk); modeFault = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_STAT, d); chk("R6 fault sticky", {31'h0, d[1]}, 32'h1);
    wr(A_STAT, 32'h02);
    rd(A_STAT, d); chk("R3 fault cleared", {31'h0, d[1]}, 32'h0);
    chk("R3 rx untouched", {31'h0, d[4]}, 32'h1);
    rxEmpty = 1'b1;

    // R6 fault and clear in the same cycle
    modeFault = 1'b1; @(negedge clk); modeFault = 1'b0;
    regWrEn = 1'b1; regAddr = A_STAT; regWrData = 32'h02; modeFault = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; modeFault = 1'b0;
    rd(A_STAT, d); chk("R6 fault wins over clear", {31'h0, d[1]}, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule